// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Add/Subtract Unit

This block performs addition and subtraction on two numbers held in sign-magnitude form. Each operand is kept as an unsigned magnitude register plus its own sign flip-flop. The first operand doubles as the accumulator: the result magnitude and sign are written back over it. Only one ripple adder is used. A complementer in front of it supplies either the second magnitude, its bitwise inverse with a carry-in of one (for magnitude subtraction), or the inverted accumulator (for the final negation). The end carry of a magnitude subtraction is kept in a carry flip-flop. That flip-flop decides whether the accumulator must be negated and its sign flipped, so no separate magnitude comparator is needed.

Software or a sequencer loads the operands while the unit is idle, picks add or subtract, and pulses start. A single-cycle done pulse marks the cycle in which the accumulator magnitude, its sign and the overflow flag hold the final values. Those values stay put until the next load or operation.

The controller has four states. IDLE accepts loads and waits for start (transition IDLE→ARITH on start). ARITH drives the adder once. It goes ARITH→FINISH when the magnitudes were added and ARITH→FIX when they were subtracted. FIX corrects a borrowed result or a zero result (FIX→FINISH). FINISH raises done (FINISH→IDLE).

Top module: `sm_addsub_unit`

## Requirements
- R1: After reset, acc_mag is 0, acc_sign is 0 (sign 0 = positive, 1 = negative), done is 0, ovf is 0, and the second operand is 0 with sign 0.
- R2: While idle, load_a stores a_mag_in/a_sign_in and load_b stores b_mag_in/b_sign_in at the clock edge. A loaded first operand shows on acc_mag/acc_sign in the next cycle.
- R3: op_sub = 0 selects addition and op_sub = 1 selects subtraction. When (acc_sign XOR second sign XOR op_sub) is 0, the magnitudes are added. The result magnitude is the sum modulo 2^W and the sign is the accumulator's original sign.
- R4: ovf is set when a magnitude addition carries out of the top magnitude bit. Each operation reloads it, and it is always 0 after an operation that subtracted magnitudes.
- R5: When magnitudes are subtracted and the accumulator magnitude exceeds the second, the result is their difference with the accumulator's original sign.
- R6: When magnitudes are subtracted and the accumulator magnitude is smaller, the result is the second magnitude minus the first, with the inverted original sign.
- R7: When magnitudes are subtracted and are equal, the result is magnitude 0 with sign 0 (never negative zero).
- R8: done is a one-cycle pulse. It appears 2 cycles after the edge that accepts start for a magnitude addition and 3 cycles after it for a magnitude subtraction. The results are final in that cycle and held afterwards.
- R9: load_a and load_b have no effect from the edge that accepts start through the done cycle.
- R10: start has no effect while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_a | input | 1 | Store first operand (accumulator) |
| a_mag_in | input | W | First operand magnitude |
| a_sign_in | input | 1 | First operand sign |
| load_b | input | 1 | Store second operand |
| b_mag_in | input | W | Second operand magnitude |
| b_sign_in | input | 1 | Second operand sign |
| op_sub | input | 1 | 0 = add, 1 = subtract, sampled with start |
| start | input | 1 | Begin an operation (accepted in IDLE) |
| acc_mag | output | W | Accumulator magnitude |
| acc_sign | output | 1 | Accumulator sign |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Magnitude-addition overflow |

## Verification
A wrong carry flip-flop or a wrong path decision shows at acc_mag/acc_sign in the done cycle of the same operation. The symptom is a two's-complement residue instead of a true difference, or a sign left uninverted. A controller that takes the wrong path moves the done pulse by one cycle, and that is visible right away. Ignored loads are checked by comparing the accumulator every cycle during the busy window, and the second operand is checked through the next operation's result. Negative zero and overflow corruption surface at the done pulse.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARITH  = 2'd1,
        ST_FIX    = 2'd2,
        ST_FINISH = 2'd3
    } sm_state_t;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_ADD  = 2'd1,
        CMD_SUB  = 2'd2,
        CMD_FIX  = 2'd3
    } dp_cmd_t;

endpackage

// File: rtl/sm_addsub_adder.sv
module sm_addsub_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign cout = carry[W];
endmodule

// File: rtl/sm_addsub_ctrl.sv
module sm_addsub_ctrl
    import sm_addsub_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    op_sub,
    input  logic    signs_differ,
    output dp_cmd_t cmd,
    output logic    load_en,
    output logic    done
);
    sm_state_t state_q, state_d;
    logic      op_q;
    logic      eff_sub;

    assign eff_sub = signs_differ ^ op_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                op_q <= op_sub;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cmd     = CMD_HOLD;
        load_en = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_en = 1'b1;
                if (start) begin
                    state_d = ST_ARITH;
                end
            end
            ST_ARITH: begin
                cmd     = eff_sub ? CMD_SUB : CMD_ADD;
                state_d = eff_sub ? ST_FIX : ST_FINISH;
            end
            ST_FIX: begin
                cmd     = CMD_FIX;
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R8: done lasts a single cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: arithmetic is only entered from idle
    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_ARITH));
endmodule

// File: rtl/sm_addsub_datapath.sv
module sm_addsub_datapath
    import sm_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dp_cmd_t      cmd,
    input  logic         load_en,
    input  logic         load_a,
    input  logic [W-1:0] a_mag_in,
    input  logic         a_sign_in,
    input  logic         load_b,
    input  logic [W-1:0] b_mag_in,
    input  logic         b_sign_in,
    output logic [W-1:0] a_q,
    output logic         as_q,
    output logic         ovf_q,
    output logic         signs_differ
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] b_q;
    logic         bs_q;
    logic         e_q;
    logic [W-1:0] opx, opy, sum;
    logic         cin, cout;

    assign signs_differ = as_q ^ bs_q;

    // complementer in front of the single adder
    always_comb begin
        opx = a_q;
        opy = b_q;
        cin = 1'b0;
        unique case (cmd)
            CMD_ADD: begin
                opx = a_q;
                opy = b_q;
                cin = 1'b0;
            end
            CMD_SUB: begin
                opx = a_q;
                opy = ~b_q;
                cin = 1'b1;
            end
            CMD_FIX: begin
                opx = ~a_q;
                opy = ZERO;
                cin = 1'b1;
            end
            default: begin
                opx = a_q;
                opy = b_q;
                cin = 1'b0;
            end
        endcase
    end

    sm_addsub_adder #(.W(W)) adder_i (
        .x    (opx),
        .y    (opy),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= ZERO;
            as_q  <= 1'b0;
            b_q   <= ZERO;
            bs_q  <= 1'b0;
            e_q   <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (load_en && load_a) begin
                a_q  <= a_mag_in;
                as_q <= a_sign_in;
            end
            if (load_en && load_b) begin
                b_q  <= b_mag_in;
                bs_q <= b_sign_in;
            end
            unique case (cmd)
                CMD_ADD: begin
                    a_q   <= sum;
                    e_q   <= cout;
                    ovf_q <= cout;
                end
                CMD_SUB: begin
                    a_q   <= sum;
                    e_q   <= cout;
                    ovf_q <= 1'b0;
                end
                CMD_FIX: begin
                    if (!e_q) begin
                        a_q  <= sum;
                        as_q <= ~as_q;
                    end else if (a_q == ZERO) begin
                        as_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: a magnitude subtraction never leaves overflow set
    assert_sub_no_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SUB) |=> !ovf_q);

    // R7: correction step never yields negative zero
    assert_no_neg_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FIX) |=> !((a_q == ZERO) && as_q));

    // R3: addition of magnitudes keeps the accumulator sign
    assert_add_keeps_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ADD) |=> $stable(as_q));

    // R9: second operand frozen while busy
    assert_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(b_q) && $stable(bs_q)));

    // R5: no borrow means magnitude untouched by correction
    assert_fix_keeps_mag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FIX && e_q) |=> $stable(a_q));
endmodule

// File: rtl/sm_addsub_unit.sv
module sm_addsub_unit
    import sm_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_a,
    input  logic [W-1:0] a_mag_in,
    input  logic         a_sign_in,
    input  logic         load_b,
    input  logic [W-1:0] b_mag_in,
    input  logic         b_sign_in,
    input  logic         op_sub,
    input  logic         start,
    output logic [W-1:0] acc_mag,
    output logic         acc_sign,
    output logic         done,
    output logic         ovf
);
    dp_cmd_t cmd;
    logic    load_en;
    logic    signs_differ;

    sm_addsub_ctrl ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .op_sub       (op_sub),
        .signs_differ (signs_differ),
        .cmd          (cmd),
        .load_en      (load_en),
        .done         (done)
    );

    sm_addsub_datapath #(.W(W)) dp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .load_en      (load_en),
        .load_a       (load_a),
        .a_mag_in     (a_mag_in),
        .a_sign_in    (a_sign_in),
        .load_b       (load_b),
        .b_mag_in     (b_mag_in),
        .b_sign_in    (b_sign_in),
        .a_q          (acc_mag),
        .as_q         (acc_sign),
        .ovf_q        (ovf),
        .signs_differ (signs_differ)
    );
endmodule

// File: tb/sm_addsub_unit_tb_top.sv
module sm_addsub_unit_tb_top;
    localparam int W    = 8;
    localparam int MODV = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_a = 1'b0, load_b = 1'b0;
    logic [W-1:0] a_mag_in = '0, b_mag_in = '0;
    logic         a_sign_in = 1'b0, b_sign_in = 1'b0;
    logic         op_sub = 1'b0, start = 1'b0;
    logic [W-1:0] acc_mag;
    logic         acc_sign, done, ovf;

    int    errors = 0;
    int    checks = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    sm_addsub_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .load_a(load_a), .a_mag_in(a_mag_in), .a_sign_in(a_sign_in),
        .load_b(load_b), .b_mag_in(b_mag_in), .b_sign_in(b_sign_in),
        .op_sub(op_sub), .start(start),
        .acc_mag(acc_mag), .acc_sign(acc_sign), .done(done), .ovf(ovf)
    );

    // behavioural reference model, advanced on each rising edge
    int m_a = 0, m_b = 0, m_phase = 0;
    bit m_as = 0, m_bs = 0, m_ovf = 0, m_done = 0, m_op = 0, m_lt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 0; m_as = 0; m_b = 0; m_bs = 0;
            m_ovf = 0; m_done = 0; m_phase = 0;
        end else begin
            case (m_phase)
                0: begin
                    m_done = 0;
                    if (load_a) begin m_a = int'(a_mag_in); m_as = a_sign_in; end
                    if (load_b) begin m_b = int'(b_mag_in); m_bs = b_sign_in; end
                    if (start) begin m_op = op_sub; m_phase = 1; end
                end
                1: begin
                    if ((m_as ^ m_bs ^ m_op) == 1'b0) begin
                        m_ovf = (m_a + m_b) >= MODV;
                        m_a = (m_a + m_b) % MODV;
                        m_done = 1; m_phase = 3;
                    end else begin
                        m_ovf = 0;
                        m_lt = m_a < m_b;
                        m_a = (m_a - m_b + MODV) % MODV;
                        m_phase = 2;
                    end
                end
                2: begin
                    if (m_lt) begin
                        m_a = (MODV - m_a) % MODV;
                        m_as = ~m_as;
                    end else if (m_a == 0) begin
                        m_as = 0;
                    end
                    m_done = 1; m_phase = 3;
                end
                default: begin
                    m_done = 0; m_phase = 0;
                end
            endcase
        end
    end

    task automatic step();
        @(negedge clk);
        checks++;
        if (int'(acc_mag) != m_a || acc_sign != m_as || done != m_done || ovf != m_ovf) begin
            errors++;
            $display("FAIL %s cycle compare: got mag=%0d sign=%0d done=%0d ovf=%0d exp mag=%0d sign=%0d done=%0d ovf=%0d",
                     cur_tag, acc_mag, acc_sign, done, ovf, m_a, m_as, m_done, m_ovf);
        end
    endtask

    task automatic expect_val(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // load both operands, start, wait for done, check latency and result
    task automatic run_op(string tag, int am, bit as, int bm, bit bs, bit sub,
                          int exp_mag, bit exp_sign, bit exp_ovf, int exp_lat,
                          bit poke_busy);
        int lat;
        cur_tag = tag;
        load_a = 1; a_mag_in = W'(am); a_sign_in = as;
        load_b = 1; b_mag_in = W'(bm); b_sign_in = bs;
        step();
        load_a = 0; load_b = 0;
        start = 1; op_sub = sub;
        step();
        start = 0;
        lat = 1;
        if (poke_busy) begin
            // R9 R10: loads and start while busy must do nothing
            load_a = 1; a_mag_in = 8'hA5; a_sign_in = ~as;
            load_b = 1; b_mag_in = 8'h3C; b_sign_in = ~bs;
            start = 1; op_sub = ~sub;
        end
        while (!done && lat < 6) begin
            step();
            lat++;
        end
        load_a = 0; load_b = 0; start = 0;
        expect_val({tag, " R8 latency"}, lat, exp_lat);
        expect_val({tag, " mag"}, int'(acc_mag), exp_mag);
        expect_val({tag, " sign"}, int'(acc_sign), int'(exp_sign));
        expect_val({tag, " ovf R4"}, int'(ovf), int'(exp_ovf));
        step();
        expect_val({tag, " R8 done single"}, int'(done), 0);
        expect_val({tag, " R8 held"}, int'(acc_mag), exp_mag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        cur_tag = "R1";
        step(); step();
        rst_n = 1;
        step();
        expect_val("R1 reset mag", int'(acc_mag), 0);
        expect_val("R1 reset sign", int'(acc_sign), 0);
        expect_val("R1 reset done", int'(done), 0);
        expect_val("R1 reset ovf", int'(ovf), 0);

        cur_tag = "R2";
        load_a = 1; a_mag_in = 8'd77; a_sign_in = 1;
        step();
        load_a = 0;
        expect_val("R2 load visible mag", int'(acc_mag), 77);
        expect_val("R2 load visible sign", int'(acc_sign), 1);

        run_op("R3 +3 + +2",       3,   0, 2,   0, 0, 5,   0, 0, 2, 0);
        run_op("R3 -200 + -100",   200, 1, 100, 1, 0, 44,  1, 1, 2, 0);
        run_op("R3 +255 - -1",     255, 0, 1,   1, 1, 0,   0, 1, 2, 0);
        run_op("R4 cleared",       10,  0, 3,   1, 0, 7,   0, 0, 3, 0);
        run_op("R5 -9 - -5",       9,   1, 5,   1, 1, 4,   1, 0, 3, 0);
        run_op("R6 +5 - +9",       5,   0, 9,   0, 1, 4,   1, 0, 3, 0);
        run_op("R6 -3 + +10",      3,   1, 10,  0, 0, 7,   0, 0, 3, 0);
        run_op("R7 -7 + +7",       7,   1, 7,   0, 0, 0,   0, 0, 3, 0);
        run_op("R7 +7 - +7",       7,   0, 7,   0, 1, 0,   0, 0, 3, 0);
        run_op("R9 busy loads sub", 20, 0, 50,  0, 1, 30,  1, 0, 3, 1);
        run_op("R10 busy start add", 40, 1, 2,  1, 0, 42,  1, 0, 2, 1);

        // R9: the second operand was not overwritten during the busy window
        cur_tag = "R9";
        start = 1; op_sub = 0;
        step();
        start = 0;
        while (!done) step();
        expect_val("R9 second operand kept", int'(acc_mag), 44);
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule